// File: doc/BRIEF.md
# PLL Divider Command Controller

This block keeps the divider settings of a clock synthesizer: a 10-bit feedback divider M, a 3-bit divider NA, and two single-bit dividers NB and P. It holds them in two separate places. The live divider set drives the synthesizer. A shadow pair of 8-bit configuration registers (low and high) is what a bus front end reads and writes. Write-only command bytes move values between the two places, and they can also step M by one in either direction.

A mode input picks who is in control. In parallel mode the live dividers and the register read values follow external pins, and software writes and commands are ignored. In serial mode the pins are ignored. The registers can then be written freely, and commands move or step the settings. Switching into serial mode keeps whatever configuration was last taken from the pins. Switching back to parallel mode hands control to the pins at once. The read-only lock indication is merged into the top bit of the high register.

Top module: `pll_divcmd_ctrl`

## Requirements
- R1: In serial mode, a command strobe whose byte has low nibble 0x1 sets M to M+1 and low nibble 0x2 sets M to M-1. The upper nibble of the command byte is ignored.
- R2: M stepping wraps modulo 1024: incrementing 1023 gives 0, and decrementing 0 gives 1023.
- R3: In serial mode, low nibble 0x4 copies the registers into the live dividers. M takes {high[1:0], low[7:0]}, NA takes high[4:2], NB takes high[5] and P takes high[6]. The copy uses the register values that held before any register write in the same cycle.
- R4: In serial mode, low nibble 0x8 copies the live dividers into the registers, using the same field layout as R3. It takes precedence over a register write in the same cycle.
- R5: A command byte whose low nibble is anything other than 0x1, 0x2, 0x4 or 0x8 leaves the dividers and the registers unchanged.
- R6: While the mode input is 0 (parallel), the divider outputs equal the pins, and the register read values show the pin configuration in the R3 layout. Register writes and commands have no effect.
- R7: When the mode input goes from 0 to 1, the dividers and registers keep the configuration last taken from the pins. When it goes from 1 to 0, the outputs show the pins in the same cycle.
- R8: In serial mode, a low-register write stores all 8 bits, and a high-register write stores bits 6..0. Bit 7 of the high read value always reflects the lock input, and written bit 7 is discarded.
- R9: While reset is asserted, the live dividers and the stored registers are zero.
- R10: A command or register write sampled at one clock edge is visible on the outputs right after that edge. That edge is the only one involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | 1 = serial control, 0 = parallel (pin) control |
| lock_in | input | 1 | PLL lock indication, read back in high bit 7 |
| pin_m | input | 10 | M divider pins |
| pin_na | input | 3 | NA divider pins |
| pin_nb | input | 1 | NB divider pin |
| pin_p | input | 1 | P divider pin |
| wr_lo | input | 1 | Write strobe for the low register |
| wr_hi | input | 1 | Write strobe for the high register |
| wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte |
| div_m | output | 10 | Live M divider |
| div_na | output | 3 | Live NA divider |
| div_nb | output | 1 | Live NB divider |
| div_p | output | 1 | Live P divider |
| reg_lo_rd | output | 8 | Low register read value |
| reg_hi_rd | output | 8 | High register read value, bit 7 is lock |

## Verification
The bench drives M across both wrap points. A design that stepped M in 11 bits, or saturated it, would read 0x400 or stick at 1023. It also issues a command with junk in the upper nibble and one with two low bits set. A decoder that tested single bits or the whole byte would misfire on these. The same-cycle collisions, a write alongside a copy-back and a write alongside a load, expose a design that lets the write win or loads the freshly written value. Mode toggles with the pins changing at the switch catch a design that samples pins after entering serial mode, or that lags one cycle when handing control back to the pins.

// File: rtl/pll_divcmd_pkg.sv
package pll_divcmd_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] CODE_INC  = 4'h1;
   localparam logic [OPC_W-1:0] CODE_DEC  = 4'h2;
   localparam logic [OPC_W-1:0] CODE_LOAD = 4'h4;
   localparam logic [OPC_W-1:0] CODE_GET  = 4'h8;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_INC,
      OP_DEC,
      OP_LOAD,
      OP_GET
   } div_op_e;

endpackage

// File: rtl/pll_divcmd_decode.sv
module pll_divcmd_decode
   import pll_divcmd_pkg::*;
#(
   parameter int CMD_W = 8
) (
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_byte,
   input  logic             serial_mode,
   output div_op_e          op
);

   generate
      if (CMD_W < OPC_W) begin : g_bad_cmd_w
         $error("CMD_W must hold the opcode nibble");
      end
   endgenerate

   logic [OPC_W-1:0] code;
   logic             unused_upper;

   assign code         = cmd_byte[OPC_W-1:0];
   assign unused_upper = ^cmd_byte[CMD_W-1:OPC_W];

   always_comb begin
      op = OP_NONE;
      if (cmd_valid && serial_mode) begin
         case (code)
            CODE_INC:  op = OP_INC;
            CODE_DEC:  op = OP_DEC;
            CODE_LOAD: op = OP_LOAD;
            CODE_GET:  op = OP_GET;
            default:   op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pll_divcmd_live.sv
module pll_divcmd_live
   import pll_divcmd_pkg::*;
#(
   parameter int M_W  = 10,
   parameter int NA_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            serial_mode,
   input  div_op_e         op,
   input  logic [M_W-1:0]  pin_m,
   input  logic [NA_W-1:0] pin_na,
   input  logic            pin_nb,
   input  logic            pin_p,
   input  logic [M_W-1:0]  ld_m,
   input  logic [NA_W-1:0] ld_na,
   input  logic            ld_nb,
   input  logic            ld_p,
   output logic [M_W-1:0]  m_q,
   output logic [NA_W-1:0] na_q,
   output logic            nb_q,
   output logic            p_q
);

   localparam logic [M_W-1:0] M_ONE = M_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q  <= '0;
         na_q <= '0;
         nb_q <= 1'b0;
         p_q  <= 1'b0;
      end else if (!serial_mode) begin
         m_q  <= pin_m;
         na_q <= pin_na;
         nb_q <= pin_nb;
         p_q  <= pin_p;
      end else begin
         case (op)
            OP_INC:  m_q <= m_q + M_ONE;
            OP_DEC:  m_q <= m_q - M_ONE;
            OP_LOAD: begin
               m_q  <= ld_m;
               na_q <= ld_na;
               nb_q <= ld_nb;
               p_q  <= ld_p;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pll_divcmd_shadow.sv
module pll_divcmd_shadow
   import pll_divcmd_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             serial_mode,
   input  div_op_e          op,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wr_data,
   input  logic [REG_W-1:0] snap_lo,
   input  logic [REG_W-2:0] snap_hi,
   output logic [REG_W-1:0] lo_q,
   output logic [REG_W-2:0] hi_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (!serial_mode || op == OP_GET) begin
         lo_q <= snap_lo;
         hi_q <= snap_hi;
      end else begin
         if (wr_lo) lo_q <= wr_data;
         if (wr_hi) hi_q <= wr_data[REG_W-2:0];
      end
   end

endmodule

// File: rtl/pll_divcmd_ctrl.sv
module pll_divcmd_ctrl
   import pll_divcmd_pkg::*;
#(
   parameter int M_W   = 10,
   parameter int NA_W  = 3,
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             serial_mode,
   input  logic             lock_in,
   input  logic [M_W-1:0]   pin_m,
   input  logic [NA_W-1:0]  pin_na,
   input  logic             pin_nb,
   input  logic             pin_p,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wr_data,
   input  logic             cmd_valid,
   input  logic [REG_W-1:0] cmd_byte,
   output logic [M_W-1:0]   div_m,
   output logic [NA_W-1:0]  div_na,
   output logic             div_nb,
   output logic             div_p,
   output logic [REG_W-1:0] reg_lo_rd,
   output logic [REG_W-1:0] reg_hi_rd
);

   localparam int M_HI_W = M_W - REG_W;
   localparam int NA_LSB = M_HI_W;
   localparam int NB_BIT = NA_LSB + NA_W;
   localparam int P_BIT  = NB_BIT + 1;

   generate
      if (M_W <= REG_W) begin : g_bad_m_w
         $error("M_W must exceed REG_W so that M spans both registers");
      end
      if (P_BIT + 2 != REG_W) begin : g_bad_layout
         $error("Divider fields plus lock must fill the high register");
      end
   endgenerate

   div_op_e          op;
   logic [M_W-1:0]   live_m;
   logic [NA_W-1:0]  live_na;
   logic             live_nb;
   logic             live_p;
   logic [REG_W-1:0] lo_q;
   logic [REG_W-2:0] hi_q;
   logic [REG_W-1:0] snap_lo;
   logic [REG_W-2:0] snap_hi;

   pll_divcmd_decode #(.CMD_W(REG_W)) u_dec (
      .cmd_valid   (cmd_valid),
      .cmd_byte    (cmd_byte),
      .serial_mode (serial_mode),
      .op          (op)
   );

   pll_divcmd_live #(.M_W(M_W), .NA_W(NA_W)) u_live (
      .clk         (clk),
      .rst_n       (rst_n),
      .serial_mode (serial_mode),
      .op          (op),
      .pin_m       (pin_m),
      .pin_na      (pin_na),
      .pin_nb      (pin_nb),
      .pin_p       (pin_p),
      .ld_m        ({hi_q[M_HI_W-1:0], lo_q}),
      .ld_na       (hi_q[NA_LSB +: NA_W]),
      .ld_nb       (hi_q[NB_BIT]),
      .ld_p        (hi_q[P_BIT]),
      .m_q         (live_m),
      .na_q        (live_na),
      .nb_q        (live_nb),
      .p_q         (live_p)
   );

   // Pins own the outputs in parallel mode; registered set in serial mode.
   assign div_m  = serial_mode ? live_m  : pin_m;
   assign div_na = serial_mode ? live_na : pin_na;
   assign div_nb = serial_mode ? live_nb : pin_nb;
   assign div_p  = serial_mode ? live_p  : pin_p;

   assign snap_lo = div_m[REG_W-1:0];
   assign snap_hi = {div_p, div_nb, div_na, div_m[M_W-1:REG_W]};

   pll_divcmd_shadow #(.REG_W(REG_W)) u_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .serial_mode (serial_mode),
      .op          (op),
      .wr_lo       (wr_lo),
      .wr_hi       (wr_hi),
      .wr_data     (wr_data),
      .snap_lo     (snap_lo),
      .snap_hi     (snap_hi),
      .lo_q        (lo_q),
      .hi_q        (hi_q)
   );

   assign reg_lo_rd = serial_mode ? lo_q : snap_lo;
   assign reg_hi_rd = {lock_in, (serial_mode ? hi_q : snap_hi)};

endmodule

// File: rtl/pll_divcmd_chk.sv
module pll_divcmd_chk #(
   parameter int M_W   = 10,
   parameter int NA_W  = 3,
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             serial_mode,
   input logic             cmd_valid,
   input logic [3:0]       cmd_code,
   input logic             wr_lo,
   input logic [REG_W-1:0] wr_data,
   input logic [M_W-1:0]   div_m,
   input logic [NA_W-1:0]  div_na,
   input logic             div_nb,
   input logic             div_p,
   input logic [REG_W-1:0] reg_lo_rd,
   input logic [REG_W-2:0] reg_hi_low
);

   localparam logic [M_W-1:0] M_STEP = M_W'(1);

   logic is_inc, is_dec, is_load, is_get, is_valid;
   logic [REG_W-2:0] div_hi;

   assign is_inc   = serial_mode && cmd_valid && cmd_code == 4'h1;
   assign is_dec   = serial_mode && cmd_valid && cmd_code == 4'h2;
   assign is_load  = serial_mode && cmd_valid && cmd_code == 4'h4;
   assign is_get   = serial_mode && cmd_valid && cmd_code == 4'h8;
   assign is_valid = is_inc || is_dec || is_load || is_get;
   assign div_hi   = {div_p, div_nb, div_na, div_m[M_W-1:REG_W]};

   // R1 and R2: step with modulo wrap
   assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_inc |=> (!serial_mode || div_m == $past(div_m) + M_STEP));

   assert_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_dec |=> (!serial_mode || div_m == $past(div_m) - M_STEP));

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> (!serial_mode ||
         (div_m[REG_W-1:0] == $past(reg_lo_rd) && div_hi == $past(reg_hi_low))));

   assert_get_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_get |=> (!serial_mode ||
         (reg_lo_rd == $past(div_m[REG_W-1:0]) && reg_hi_low == $past(div_hi))));

   assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (serial_mode && !is_valid) |=> (!serial_mode ||
         ($stable(div_m) && $stable(div_na) && $stable(div_nb) && $stable(div_p))));

   assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !serial_mode |-> (reg_lo_rd == div_m[REG_W-1:0] && reg_hi_low == div_hi));

   assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(serial_mode) && $past(rst_n)) |->
         ($stable(div_m) && $stable(div_na) && $stable(div_nb) && $stable(div_p)));

   assert_wrlo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (serial_mode && wr_lo && !is_get) |=> (!serial_mode || reg_lo_rd == $past(wr_data)));

endmodule

bind pll_divcmd_ctrl pll_divcmd_chk #(.M_W(M_W), .NA_W(NA_W), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .serial_mode (serial_mode),
   .cmd_valid   (cmd_valid),
   .cmd_code    (cmd_byte[3:0]),
   .wr_lo       (wr_lo),
   .wr_data     (wr_data),
   .div_m       (div_m),
   .div_na      (div_na),
   .div_nb      (div_nb),
   .div_p       (div_p),
   .reg_lo_rd   (reg_lo_rd),
   .reg_hi_low  (reg_hi_rd[REG_W-2:0])
);

// File: tb/pll_divcmd_ctrl_tb_top.sv
module pll_divcmd_ctrl_tb_top;

   typedef struct packed {
      logic [3:0] req;
      logic       mode;
      logic       wl;
      logic       wh;
      logic [7:0] wd;
      logic       cv;
      logic [7:0] cmd;
      logic [9:0] pm;
      logic [2:0] pna;
      logic       pnb;
      logic       pp;
      logic [9:0] em;
      logic [2:0] ena;
      logic       enb;
      logic       ep;
      logic [7:0] elo;
      logic [6:0] ehi;
   } vec_t;

   localparam int NV = 21;
   // pins A: m=155 na=5 nb=1 p=0 ; pins B: m=0F0 na=2 nb=0 p=1
   localparam vec_t VECS [NV] = '{
      '{4'd6, 0,0,0,8'h00,0,8'h00, 10'h155,3'd5,1,0, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R6
      '{4'd6, 0,1,0,8'hAA,0,8'h00, 10'h155,3'd5,1,0, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R6 write ignored
      '{4'd6, 0,0,0,8'h00,1,8'h01, 10'h155,3'd5,1,0, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R6 command ignored
      '{4'd7, 1,0,0,8'h00,0,8'h00, 10'h0F0,3'd2,0,1, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R7 keep on entry
      '{4'd1, 1,0,0,8'h00,1,8'h01, 10'h0F0,3'd2,0,1, 10'h156,3'd5,1,0, 8'h55,7'h35}, // R1 inc, R10
      '{4'd1, 1,0,0,8'h00,1,8'hF2, 10'h0F0,3'd2,0,1, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R1 dec, upper nibble
      '{4'd5, 1,0,0,8'h00,1,8'h03, 10'h0F0,3'd2,0,1, 10'h155,3'd5,1,0, 8'h55,7'h35}, // R5
      '{4'd8, 1,1,0,8'hFF,0,8'h00, 10'h0F0,3'd2,0,1, 10'h155,3'd5,1,0, 8'hFF,7'h35}, // R8 low write
      '{4'd8, 1,0,1,8'hFB,0,8'h00, 10'h0F0,3'd2,0,1, 10'h155,3'd5,1,0, 8'hFF,7'h7B}, // R8 high write
      '{4'd3, 1,0,0,8'h00,1,8'h04, 10'h0F0,3'd2,0,1, 10'h3FF,3'd6,1,1, 8'hFF,7'h7B}, // R3 load
      '{4'd2, 1,0,0,8'h00,1,8'h01, 10'h0F0,3'd2,0,1, 10'h000,3'd6,1,1, 8'hFF,7'h7B}, // R2 wrap up
      '{4'd2, 1,0,0,8'h00,1,8'h02, 10'h0F0,3'd2,0,1, 10'h3FF,3'd6,1,1, 8'hFF,7'h7B}, // R2 wrap down
      '{4'd1, 1,0,0,8'h00,1,8'h02, 10'h0F0,3'd2,0,1, 10'h3FE,3'd6,1,1, 8'hFF,7'h7B}, // R1
      '{4'd4, 1,1,0,8'h00,1,8'h08, 10'h0F0,3'd2,0,1, 10'h3FE,3'd6,1,1, 8'hFE,7'h7B}, // R4 beats write
      '{4'd8, 1,1,0,8'h34,0,8'h00, 10'h0F0,3'd2,0,1, 10'h3FE,3'd6,1,1, 8'h34,7'h7B}, // R8
      '{4'd3, 1,1,0,8'h56,1,8'h04, 10'h0F0,3'd2,0,1, 10'h334,3'd6,1,1, 8'h56,7'h7B}, // R3 old values
      '{4'd7, 0,0,0,8'h00,0,8'h00, 10'h0F0,3'd2,0,1, 10'h0F0,3'd2,0,1, 8'hF0,7'h48}, // R7 pins at once
      '{4'd6, 0,0,0,8'h00,1,8'h08, 10'h0F0,3'd2,0,1, 10'h0F0,3'd2,0,1, 8'hF0,7'h48}, // R6 get ignored
      '{4'd7, 1,0,0,8'h00,0,8'h00, 10'h155,3'd5,1,0, 10'h0F0,3'd2,0,1, 8'hF0,7'h48}, // R7
      '{4'd8, 1,0,1,8'h80,0,8'h00, 10'h155,3'd5,1,0, 10'h0F0,3'd2,0,1, 8'hF0,7'h00}, // R8 bit 7 dropped
      '{4'd3, 1,0,0,8'h00,1,8'h04, 10'h155,3'd5,1,0, 10'h0F0,3'd0,0,0, 8'hF0,7'h00}  // R3
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       serial_mode = 1'b1;
   logic       lock_in = 1'b0;
   logic [9:0] pin_m = '0;
   logic [2:0] pin_na = '0;
   logic       pin_nb = 1'b0;
   logic       pin_p = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic [9:0] div_m;
   logic [2:0] div_na;
   logic       div_nb;
   logic       div_p;
   logic [7:0] reg_lo_rd;
   logic [7:0] reg_hi_rd;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pll_divcmd_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .serial_mode (serial_mode), .lock_in (lock_in),
      .pin_m (pin_m), .pin_na (pin_na), .pin_nb (pin_nb), .pin_p (pin_p),
      .wr_lo (wr_lo), .wr_hi (wr_hi), .wr_data (wr_data),
      .cmd_valid (cmd_valid), .cmd_byte (cmd_byte),
      .div_m (div_m), .div_na (div_na), .div_nb (div_nb), .div_p (div_p),
      .reg_lo_rd (reg_lo_rd), .reg_hi_rd (reg_hi_rd)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_lo = 1'b0; wr_hi = 1'b0; cmd_valid = 1'b0; cmd_byte = '0; wr_data = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R9: reset clears live and stored state (serial mode shows them)
      check("R9 reset", {div_m, div_na, div_nb, div_p, reg_lo_rd, reg_hi_rd},
            {10'h0, 3'h0, 1'b0, 1'b0, 8'h00, 8'h00});
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         serial_mode = VECS[i].mode;
         wr_lo = VECS[i].wl; wr_hi = VECS[i].wh; wr_data = VECS[i].wd;
         cmd_valid = VECS[i].cv; cmd_byte = VECS[i].cmd;
         pin_m = VECS[i].pm; pin_na = VECS[i].pna; pin_nb = VECS[i].pnb; pin_p = VECS[i].pp;
         @(posedge clk);
         #1;
         check($sformatf("R%0d vector %0d", VECS[i].req, i),
               {div_m, div_na, div_nb, div_p, reg_lo_rd, reg_hi_rd},
               {VECS[i].em, VECS[i].ena, VECS[i].enb, VECS[i].ep, VECS[i].elo, 1'b0, VECS[i].ehi});
      end

      // R8: lock input shows in high bit 7 (serial, stored high = 0)
      @(negedge clk);
      idle_inputs();
      lock_in = 1'b1;
      #1;
      check("R8 lock bit", {24'h0, reg_hi_rd}, {24'h0, 8'h80});

      // R5: two opcode bits set is not a valid command
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = 8'h0C;
      @(posedge clk);
      #1;
      check("R5 double code", {div_m, div_na, div_nb, div_p, reg_lo_rd},
            {10'h0F0, 3'd0, 1'b0, 1'b0, 8'hF0});

      // R10: a strobe affects exactly one edge
      @(negedge clk);
      cmd_byte = 8'h01;
      @(posedge clk);
      #1;
      @(negedge clk);
      idle_inputs();
      @(posedge clk);
      #1;
      check("R10 single step", {22'h0, div_m}, {22'h0, 10'h0F1});

      // R9: reset in the middle of serial operation
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R9 mid reset", {div_m, div_na, div_nb, div_p, reg_lo_rd, reg_hi_rd},
            {10'h0, 3'h0, 1'b0, 1'b0, 8'h00, 8'h80});

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

endmodule